// File: doc/BRIEF.md
# DRAM Initialization Sequencer

This block prepares memory behind a controller once software turns the controller on, before normal traffic is let through. Software loads a set of configuration fields and then raises the memory-enable field. If control-word programming is wanted and not bypassed, the sequencer first sends the two programmed register-control-word values to the registered module, in a fixed order. If software has also raised the fill-request field, it then writes a programmed pattern word into every location, from address zero upward. When both phases are over, the block raises a one-cycle completion pulse.

The fill-request field is set by software and cleared only by hardware. It reads back as set from the moment it is accepted until the last fill write has been taken. Requests leave on a single valid/ready port. Each request is tagged as either a control-word write or a data write. Mode-register programming and calibration are not part of this block.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, `req_valid`, `init_done` and `fill_pending` are all 0, and no request is presented until memory enable is written as 1.
- R2: A configuration write with `sw_fill_req`=1 while the sequencer is idle makes `fill_pending` read 1 from the next cycle. It stays 1 through every fill write and drops to 0 once the last fill write is accepted.
- R3: A configuration write with `sw_fill_req`=1 while the sequencer is not idle has no effect. It is not idle while sending control words, while filling, or after completion until memory enable is cleared. In that case `fill_pending` stays 0 and no fill writes follow.
- R4: With control words enabled and bypass clear, enabling memory first produces exactly two requests with `req_kind`=0. The first carries `req_addr`=0 and the first control word, zero-extended. The second carries `req_addr`=1 and the second control word. Both come before any other request.
- R5: With bypass set, no request with `req_kind`=0 is issued, whatever the control-word enable is.
- R6: When a fill is pending at enable, exactly DEPTH requests with `req_kind`=1 are issued. Their addresses run 0, 1, …, DEPTH-1 in that order, and each carries the pattern word.
- R7: A presented request keeps `req_valid`, `req_kind`, `req_addr` and `req_data` unchanged until `req_ready` is 1. The sequence advances only on a handshake.
- R8: `init_done` is 1 for exactly one cycle, in the cycle after the final request is accepted, or two cycles after enable when there is nothing to do. No request follows it until memory enable is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| sw_wr | input | 1 | Configuration write strobe; all fields below are captured |
| sw_mem_en | input | 1 | Memory enable field |
| sw_skip_init | input | 1 | Bypass field: suppresses control-word writes |
| sw_cw_en | input | 1 | Control-word programming enable field |
| sw_fill_req | input | 1 | Fill request; 1 sets the pending flag if idle, 0 has no effect |
| sw_cw_a | input | CW_W | First control-word value |
| sw_cw_b | input | CW_W | Second control-word value |
| sw_pattern | input | DATA_W | Fill pattern word |
| fill_pending | output | 1 | Readback of the fill request flag |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the command side |
| req_kind | output | 1 | 0 = control-word write, 1 = data write |
| req_addr | output | AW | Control-word index or fill address |
| req_data | output | DATA_W | Control-word value or pattern |
| init_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a fill request that arrives while the sequencer is busy. The write must land during the short window in which the sequencer has left idle. To reach it, the bench holds `req_ready` low so the sequencer sits on the first control word. It then issues the fill-request write and releases ready, and checks that the flag never rose and that only the two control words appear. A second case issues the same write after completion, while memory enable is still set.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_CW1  = 3'd1,
    SQ_CW2  = 3'd2,
    SQ_FILL = 3'd3,
    SQ_DONE = 3'd4
  } seq_state_t;

  localparam logic KIND_CW   = 1'b0;
  localparam logic KIND_FILL = 1'b1;
endpackage

// File: rtl/dinit_cfg_regs.sv
module dinit_cfg_regs #(
  parameter int CW_W   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_mem_en,
  input  logic              sw_skip_init,
  input  logic              sw_cw_en,
  input  logic              sw_fill_req,
  input  logic [CW_W-1:0]   sw_cw_a,
  input  logic [CW_W-1:0]   sw_cw_b,
  input  logic [DATA_W-1:0] sw_pattern,
  input  logic              seq_idle,
  input  logic              fill_clear,
  output logic              mem_en_q,
  output logic              skip_q,
  output logic              cw_en_q,
  output logic              pend_q,
  output logic [CW_W-1:0]   cw_a_q,
  output logic [CW_W-1:0]   cw_b_q,
  output logic [DATA_W-1:0] pat_q
);
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (fill_clear)
      pend_d = 1'b0;
    else if (sw_wr && sw_fill_req && seq_idle)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en_q <= 1'b0;
      skip_q   <= 1'b0;
      cw_en_q  <= 1'b0;
      cw_a_q   <= '0;
      cw_b_q   <= '0;
      pat_q    <= '0;
    end else if (sw_wr) begin
      mem_en_q <= sw_mem_en;
      skip_q   <= sw_skip_init;
      cw_en_q  <= sw_cw_en;
      cw_a_q   <= sw_cw_a;
      cw_b_q   <= sw_cw_b;
      pat_q    <= sw_pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_PEND_RISE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(seq_idle)); // R3
  AST_PEND_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(fill_clear)); // R2
endmodule

// File: rtl/dinit_fill_ctr.sv
module dinit_fill_ctr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  logic [AW-1:0] addr_d;

  assign last = (addr == LAST_ADDR);

  always_comb begin
    addr_d = addr;
    if (clr)
      addr_d = '0;
    else if (step)
      addr_d = last ? '0 : addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/dinit_seq_fsm.sv
module dinit_seq_fsm
  import dinit_pkg::*;
#(
  parameter int CW_W   = 16,
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              skip,
  input  logic              cw_en,
  input  logic              pend,
  input  logic [CW_W-1:0]   cw_a,
  input  logic [CW_W-1:0]   cw_b,
  input  logic [DATA_W-1:0] pat,
  input  logic [AW-1:0]     fill_addr,
  input  logic              fill_last,
  input  logic              req_ready,
  output logic              seq_idle,
  output logic              fill_active,
  output logic              fill_clear,
  output logic              req_valid,
  output logic              req_kind,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              init_done
);
  seq_state_t state_q, state_d;
  logic done_q, done_d, hs;

  assign hs          = req_valid && req_ready;
  assign seq_idle    = (state_q == SQ_IDLE);
  assign fill_active = (state_q == SQ_FILL);
  assign fill_clear  = fill_active && req_ready && fill_last;
  assign init_done   = done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (mem_en) begin
        if (cw_en && !skip) state_d = SQ_CW1;
        else if (pend)      state_d = SQ_FILL;
        else                state_d = SQ_DONE;
      end
      SQ_CW1:  if (hs) state_d = SQ_CW2;
      SQ_CW2:  if (hs) state_d = pend ? SQ_FILL : SQ_DONE;
      SQ_FILL: if (hs && fill_last) state_d = SQ_DONE;
      SQ_DONE: if (!mem_en) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
    done_d = (state_d == SQ_DONE) && (state_q != SQ_DONE);
  end

  always_comb begin
    req_valid = 1'b0;
    req_kind  = KIND_CW;
    req_addr  = '0;
    req_data  = '0;
    case (state_q)
      SQ_CW1: begin
        req_valid = 1'b1;
        req_data  = DATA_W'(cw_a);
      end
      SQ_CW2: begin
        req_valid = 1'b1;
        req_addr  = AW'(1);
        req_data  = DATA_W'(cw_b);
      end
      SQ_FILL: begin
        req_valid = 1'b1;
        req_kind  = KIND_FILL;
        req_addr  = fill_addr;
        req_data  = pat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) && $stable(req_addr) && $stable(req_data)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done); // R8
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !req_valid); // R8
  AST_BYPASS_NO_CW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CW1) && $past(state_q == SQ_IDLE) |-> $past(!skip)); // R5
  AST_FILL_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FILL) && $past(state_q != SQ_FILL) |-> (fill_addr == '0)); // R6
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int DEPTH  = 16,
  parameter int CW_W   = 16,
  parameter int DATA_W = 32,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_mem_en,
  input  logic              sw_skip_init,
  input  logic              sw_cw_en,
  input  logic              sw_fill_req,
  input  logic [CW_W-1:0]   sw_cw_a,
  input  logic [CW_W-1:0]   sw_cw_b,
  input  logic [DATA_W-1:0] sw_pattern,
  output logic              fill_pending,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_kind,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              init_done
);
  logic mem_en_q, skip_q, cw_en_q, pend_q;
  logic [CW_W-1:0]   cw_a_q, cw_b_q;
  logic [DATA_W-1:0] pat_q;
  logic seq_idle, fill_active, fill_clear, fill_last;
  logic [AW-1:0] fill_addr;

  assign fill_pending = pend_q;

  dinit_cfg_regs #(.CW_W(CW_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mem_en(sw_mem_en),
    .sw_skip_init(sw_skip_init), .sw_cw_en(sw_cw_en), .sw_fill_req(sw_fill_req),
    .sw_cw_a(sw_cw_a), .sw_cw_b(sw_cw_b), .sw_pattern(sw_pattern),
    .seq_idle(seq_idle), .fill_clear(fill_clear),
    .mem_en_q(mem_en_q), .skip_q(skip_q), .cw_en_q(cw_en_q), .pend_q(pend_q),
    .cw_a_q(cw_a_q), .cw_b_q(cw_b_q), .pat_q(pat_q)
  );

  dinit_fill_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!fill_active),
    .step(fill_active && req_ready), .addr(fill_addr), .last(fill_last)
  );

  dinit_seq_fsm #(.CW_W(CW_W), .DATA_W(DATA_W), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en_q), .skip(skip_q), .cw_en(cw_en_q),
    .pend(pend_q), .cw_a(cw_a_q), .cw_b(cw_b_q), .pat(pat_q),
    .fill_addr(fill_addr), .fill_last(fill_last), .req_ready(req_ready),
    .seq_idle(seq_idle), .fill_active(fill_active), .fill_clear(fill_clear),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .init_done(init_done)
  );
endmodule

// File: tb/dram_init_seq_test.sv
module dram_init_seq_test;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  typedef struct packed {
    logic        cw_en;
    logic        skip;
    logic        fill;
    logic [1:0]  mode;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] pat;
    logic [1:0]  exp_cw;
    logic        exp_fill;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 1'b0, 1'b1, 2'd0, 16'h1234, 16'hABCD, 32'hDEADBEEF, 2'd2, 1'b1},
    '{1'b1, 1'b1, 1'b1, 2'd1, 16'h1111, 16'h2222, 32'h0F0F0F0F, 2'd0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 2'd2, 16'h3333, 16'h4444, 32'hA5A5A5A5, 2'd0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 2'd1, 16'hBEEF, 16'hCAFE, 32'h12345678, 2'd2, 1'b0},
    '{1'b0, 1'b0, 1'b0, 2'd0, 16'h5555, 16'h6666, 32'hFFFFFFFF, 2'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd2, 16'h7777, 16'h8888, 32'h00000001, 2'd0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 2'd2, 16'hFFFF, 16'h0001, 32'h00000000, 2'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic sw_wr, sw_mem_en, sw_skip_init, sw_cw_en, sw_fill_req;
  logic [15:0] sw_cw_a, sw_cw_b;
  logic [31:0] sw_pattern;
  logic fill_pending, req_valid, req_ready, req_kind, init_done;
  logic [AW-1:0] req_addr;
  logic [31:0] req_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int log_n = 0, done_cnt = 0;
  logic [1:0] rdy_mode = 2'd0;
  logic        lg_kind [0:63];
  logic [AW-1:0] lg_addr [0:63];
  logic [31:0] lg_data [0:63];
  logic        lg_pend [0:63];

  always #4 clk = ~clk;

  dram_init_seq #(.DEPTH(DEPTH), .CW_W(16), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mem_en(sw_mem_en),
    .sw_skip_init(sw_skip_init), .sw_cw_en(sw_cw_en), .sw_fill_req(sw_fill_req),
    .sw_cw_a(sw_cw_a), .sw_cw_b(sw_cw_b), .sw_pattern(sw_pattern),
    .fill_pending(fill_pending), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready driver and request monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      2'd0: req_ready = 1'b1;
      2'd1: req_ready = cyc[0];
      2'd2: req_ready = (cyc[1:0] == 2'b11);
      default: req_ready = 1'b0;
    endcase
    if (!rst_n) req_ready = 1'b0;
    if (req_valid && req_ready && log_n < 64) begin
      lg_kind[log_n] = req_kind;
      lg_addr[log_n] = req_addr;
      lg_data[log_n] = req_data;
      lg_pend[log_n] = fill_pending;
      log_n++;
    end
    if (init_done) done_cnt++;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(input logic me, input logic cwe, input logic sk, input logic fr,
                           input logic [15:0] a, input logic [15:0] b, input logic [31:0] p);
    @(negedge clk);
    sw_wr = 1'b1; sw_mem_en = me; sw_cw_en = cwe; sw_skip_init = sk;
    sw_fill_req = fr; sw_cw_a = a; sw_cw_b = b; sw_pattern = p;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic go_idle();
    cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int t = 0; t < 2000 && done_cnt == 0; t++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int ncw, nf, snap;
    go_idle();
    rdy_mode = v.mode;
    cfg_write(1'b0, v.cw_en, v.skip, v.fill, v.a, v.b, v.pat);
    chk(fill_pending == v.fill, $sformatf("R2 vec%0d pending after request", idx), fill_pending, v.fill);
    log_n = 0; done_cnt = 0;
    cfg_write(1'b1, v.cw_en, v.skip, 1'b0, v.a, v.b, v.pat);
    wait_done();
    snap = log_n;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, $sformatf("R8 vec%0d single done pulse", idx), done_cnt, 1);
    chk(log_n == snap, $sformatf("R8 vec%0d no request after done", idx), log_n, snap);
    ncw = int'(v.exp_cw);
    nf  = v.exp_fill ? DEPTH : 0;
    chk(log_n == ncw + nf, $sformatf("R4 R5 R6 vec%0d request count", idx), log_n, ncw + nf);
    if (log_n == ncw + nf) begin
      for (int i = 0; i < ncw; i++) begin
        chk(lg_kind[i] == 1'b0 && lg_addr[i] == AW'(i) && lg_data[i] == {16'h0, (i == 0) ? v.a : v.b},
            $sformatf("R4 vec%0d control word %0d", idx, i), {lg_kind[i], lg_addr[i], lg_data[i]},
            {1'b0, AW'(i), 16'h0, (i == 0) ? v.a : v.b});
      end
      for (int j = 0; j < nf; j++) begin
        chk(lg_kind[ncw+j] == 1'b1 && lg_addr[ncw+j] == AW'(j) && lg_data[ncw+j] == v.pat,
            $sformatf("R6 vec%0d fill %0d", idx, j), {lg_kind[ncw+j], lg_addr[ncw+j], lg_data[ncw+j]},
            {1'b1, AW'(j), v.pat});
        chk(lg_pend[ncw+j] == 1'b1, $sformatf("R2 vec%0d pending during fill", idx), lg_pend[ncw+j], 1);
      end
    end
    chk(fill_pending == 1'b0, $sformatf("R2 vec%0d pending cleared", idx), fill_pending, 0);
  endtask

  initial begin
    rst_n = 1'b0; sw_wr = 1'b0; sw_mem_en = 1'b0; sw_skip_init = 1'b0;
    sw_cw_en = 1'b0; sw_fill_req = 1'b0; sw_cw_a = '0; sw_cw_b = '0; sw_pattern = '0;
    req_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!req_valid && !init_done && !fill_pending, "R1 reset state",
          {req_valid, init_done, fill_pending}, 3'b000);
    end

    for (int i = 0; i < 7; i++) run_vec(VECS[i], i);

    // R3: fill request after completion, memory still enabled
    log_n = 0;
    cfg_write(1'b1, 1'b1, 1'b0, 1'b1, 16'h1234, 16'hABCD, 32'h1);
    repeat (20) @(negedge clk);
    chk(fill_pending == 1'b0, "R3 request in done state ignored", fill_pending, 0);
    chk(log_n == 0, "R3 no fill after ignored request", log_n, 0);

    // R3 / R7: request while stalled on the first control word
    go_idle();
    rdy_mode = 2'd3;
    cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 16'h0A0B, 16'h0C0D, 32'h99);
    log_n = 0; done_cnt = 0;
    cfg_write(1'b1, 1'b1, 1'b0, 1'b0, 16'h0A0B, 16'h0C0D, 32'h99);
    repeat (3) @(negedge clk);
    chk(req_valid && req_kind == 1'b0 && req_addr == '0 && req_data == 32'h0A0B,
        "R7 request held while stalled", {req_valid, req_kind, req_addr, req_data},
        {1'b1, 1'b0, AW'(0), 32'h0A0B});
    cfg_write(1'b1, 1'b1, 1'b0, 1'b1, 16'h0A0B, 16'h0C0D, 32'h99);
    chk(fill_pending == 1'b0, "R3 request while busy ignored", fill_pending, 0);
    repeat (4) @(negedge clk);
    chk(req_valid && req_addr == '0 && req_data == 32'h0A0B, "R7 still held after long stall",
        {req_valid, req_addr, req_data}, {1'b1, AW'(0), 32'h0A0B});
    rdy_mode = 2'd0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(log_n == 2, "R3 only control words issued", log_n, 2);
    chk(done_cnt == 1, "R8 done after stalled run", done_cnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule